// File: doc/BRIEF.md
# Keystroke Program Step Sequencer

This block stores and replays a keystroke program for a small decimal calculator. While no program is running, each code-entry strobe turns a numeral key into a 4-bit instruction code and writes it at the current step of the active bank. A decimal-point flag that comes with the same strobe turns on the code's top bit, which reaches codes 8 to 15. After the write the step counter moves on by one. The store has two banks of 15 steps. Each bank keeps its own step counter in a sixteenth digit slot, at index 0. With chaining enabled, the first bank runs on into the second, which makes one 30-step program.

A run strobe puts the counter back to step 1 of the selected bank and starts the sequencer. The downstream executor asks for steps one at a time with a fetch request. Each request returns the stored code one cycle later and moves the counter on. A stop code (14) parks the sequencer until number entry finishes and a resume strobe arrives. An end code (15), or running past the last step, finishes the run and raises a completion flag. Executing the fetched functions is the job of the neighbouring datapath.

Top module: `prog_step_seq`

## Requirements
- R1: After reset, running, halted, complete, fetch_valid, entry_ack and entry_reject are all 0. The active bank is 0 (bank 1) and cur_pc reads 1.
- R2: An accepted entry with ent_point=0 and ent_digit 0..9 stores code ent_digit at the current step. It pulses entry_ack and moves cur_pc on by one.
- R3: An entry with ent_point=1 and ent_digit in 0..7, excluding 5, stores code 8+ent_digit. For example, 2 with the point gives 10 and 7 with the point gives 15.
- R4: An entry of digit 5 with the point (code 13, reserved for internal use) is rejected. So is any digit above 7 with the point, and any digit above 9 without it. A rejection pulses entry_reject and leaves the stored steps and cur_pc unchanged.
- R5: run_go sets the active bank to bank_sel (0 = bank 1, 1 = bank 2) and cur_pc to 1, and sets running. pc_clear does the same but enters the idle state. run_go takes priority over pc_clear, and pc_clear over ent_stb.
- R6: While running, a fetch_req gives fetch_valid=1 one cycle later, with fetch_code equal to the code at the current step, and cur_pc moves on by one.
- R7: Fetching code 14 sets halted. While halted, fetch_req yields no fetch_valid. A resume strobe returns to running, and the next fetch returns the following step.
- R8: Fetching code 15 sets complete and clears running in the same cycle that the code appears on fetch_code.
- R9: With chain_en=1, moving on from step 15 of bank 1 switches the active bank to bank 2 with cur_pc=1. This applies to both entry and fetch.
- R10: Moving on from step 15 with chaining off, or from step 15 of bank 2, leaves cur_pc=0 (exhausted). An entry at cur_pc=0 is rejected. A fetch at cur_pc=0 sets complete without fetch_valid.
- R11: The two banks are independent. Writing steps in one bank leaves the other bank's codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank picked by run_go or pc_clear (0 = bank 1) |
| chain_en | input | 1 | Chain bank 1 into bank 2 as one 30-step program |
| pc_clear | input | 1 | Reset the selected bank's counter to step 1 and go idle |
| ent_stb | input | 1 | Code-entry strobe (ignored while running or halted) |
| ent_digit | input | 4 | Numeral key value for the entry |
| ent_point | input | 1 | Decimal-point key pressed with this entry |
| run_go | input | 1 | Start a run from step 1 of bank_sel |
| fetch_req | input | 1 | Executor requests the next step |
| resume | input | 1 | Number entry done, leave the stop halt |
| fetch_valid | output | 1 | fetch_code holds a fetched step |
| fetch_code | output | 4 | Fetched instruction code |
| entry_ack | output | 1 | Entry accepted and stored |
| entry_reject | output | 1 | Entry refused, store unchanged |
| running | output | 1 | Sequencer is fetching |
| halted | output | 1 | Parked on a stop code |
| complete | output | 1 | Run finished |
| cur_bank | output | 1 | Active bank (0 = bank 1) |
| cur_pc | output | 4 | Active bank's step counter (0 = exhausted) |

## Verification
Every result is registered on the edge that samples its strobe. This covers entry_ack, entry_reject, fetch_valid, fetch_code and the status flags. The new cur_pc and cur_bank also take effect after that one edge. The bench drives each strobe for exactly one cycle starting at a falling edge, then samples all outputs at the next falling edge, which is the one cycle after the strobe was taken. This matches the one-cycle pulse width of the acknowledge and data-valid outputs. Stored codes are read back through a later run and compared with codes that bench functions predict from the key and point values.

// File: rtl/prog_step_pkg.sv
package prog_step_pkg;

    localparam int CODE_W     = 4;
    localparam int STEPS      = 15;
    localparam int PC_W       = $clog2(STEPS + 1);
    localparam int BANK_DEPTH = STEPS + 1;
    localparam int NBANKS     = 2;
    localparam int KEY_MAX    = 9;
    localparam int POINT_MAX  = 7;

    typedef enum logic [CODE_W-1:0] {
        OP_NOP   = 4'd0,
        OP_NEG   = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_MEM1  = 4'd4,
        OP_MEM2  = 4'd5,
        OP_MEM3  = 4'd6,
        OP_MEM4  = 4'd7,
        OP_MUL   = 4'd8,
        OP_DIV   = 4'd9,
        OP_CLRA  = 4'd10,
        OP_CLRE  = 4'd11,
        OP_ROOT  = 4'd12,
        OP_ROOT2 = 4'd13,
        OP_STOP  = 4'd14,
        OP_END   = 4'd15
    } op_code_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_HALT = 2'd2,
        SQ_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic            bank;
        logic [PC_W-1:0] pc;
    } step_pos_t;

    typedef struct packed {
        logic              ok;
        logic [CODE_W-1:0] code;
    } key_code_t;

    function automatic key_code_t key_to_code(input logic [3:0] digit, input logic point);
        key_code_t r;
        if (point) begin
            r.code = {1'b1, digit[2:0]};
            r.ok   = (int'(digit) <= POINT_MAX) && ({1'b1, digit[2:0]} != OP_ROOT2);
        end else begin
            r.code = digit;
            r.ok   = (int'(digit) <= KEY_MAX);
        end
        return r;
    endfunction

    function automatic step_pos_t step_advance(input step_pos_t p, input logic chain);
        step_pos_t r;
        if (p.pc == PC_W'(STEPS)) begin
            if (chain && !p.bank) begin
                r.bank = 1'b1;
                r.pc   = PC_W'(1);
            end else begin
                r.bank = p.bank;
                r.pc   = '0;
            end
        end else begin
            r.bank = p.bank;
            r.pc   = p.pc + PC_W'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/key_code_enc.sv
module key_code_enc
    import prog_step_pkg::*;
(
    input  logic [3:0]        digit,
    input  logic              point,
    output logic              code_ok,
    output logic [CODE_W-1:0] code
);
    key_code_t kc;

    always_comb begin
        kc      = key_to_code(digit, point);
        code_ok = kc.ok;
        code    = kc.code;
    end
endmodule

// File: rtl/step_store.sv
module step_store
    import prog_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_we,
    input  logic              st_bank,
    input  logic [PC_W-1:0]   st_idx,
    input  logic [CODE_W-1:0] st_data,
    input  logic              pc_we,
    input  logic              pc_bank,
    input  logic [PC_W-1:0]   pc_data,
    input  logic              rd_bank,
    output logic [PC_W-1:0]   pc_rd,
    output logic [CODE_W-1:0] step_rd
);
    // digit 0 of each bank is its step counter; digits 1..STEPS hold codes
    logic [CODE_W-1:0] mem [NBANKS][BANK_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANKS; b++) begin
                for (int i = 0; i < BANK_DEPTH; i++) begin
                    mem[b][i] <= (i == 0) ? CODE_W'(1) : '0;
                end
            end
        end else begin
            if (st_we) mem[st_bank][st_idx] <= st_data;
            if (pc_we) mem[pc_bank][0] <= CODE_W'(pc_data);
        end
    end

    always_comb begin
        pc_rd   = PC_W'(mem[rd_bank][0]);
        step_rd = mem[rd_bank][pc_rd];
    end

    // R2
    step_write_not_counter_chk: assert property (@(posedge clk) disable iff (rst)
        st_we |-> st_idx != '0);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import prog_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic              chain_en,
    input  logic              pc_clear,
    input  logic              ent_stb,
    input  logic              run_go,
    input  logic              fetch_req,
    input  logic              resume,
    input  logic              key_ok,
    input  logic [CODE_W-1:0] key_code,
    input  logic [PC_W-1:0]   pc_rd,
    input  logic [CODE_W-1:0] step_rd,
    output logic              st_we,
    output logic              st_bank,
    output logic [PC_W-1:0]   st_idx,
    output logic [CODE_W-1:0] st_data,
    output logic              pc_we,
    output logic              pc_bank,
    output logic [PC_W-1:0]   pc_data,
    output logic              bank_q,
    output logic              fetch_valid_q,
    output logic [CODE_W-1:0] fetch_code_q,
    output logic              entry_ack_q,
    output logic              entry_rej_q,
    output logic              running,
    output logic              halted,
    output logic              complete
);
    seq_state_e state_q;
    step_pos_t  cur_pos, nxt_pos;
    logic       busy, ent_take, do_entry, do_fetch, fetch_live;

    always_comb begin
        cur_pos.bank = bank_q;
        cur_pos.pc   = pc_rd;
        nxt_pos      = step_advance(cur_pos, chain_en);
        busy         = (state_q == SQ_RUN) || (state_q == SQ_HALT);
        ent_take     = ent_stb && !busy && !run_go && !pc_clear;
        do_entry     = ent_take && key_ok && (pc_rd != '0);
        fetch_live   = (state_q == SQ_RUN) && fetch_req && !run_go && !pc_clear;
        do_fetch     = fetch_live && (pc_rd != '0);

        st_we   = do_entry;
        st_bank = bank_q;
        st_idx  = pc_rd;
        st_data = key_code;

        pc_we   = 1'b0;
        pc_bank = nxt_pos.bank;
        pc_data = nxt_pos.pc;
        if (run_go || pc_clear) begin
            pc_we   = 1'b1;
            pc_bank = bank_sel;
            pc_data = PC_W'(1);
        end else if (do_entry || do_fetch) begin
            pc_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= SQ_IDLE;
            bank_q        <= 1'b0;
            fetch_valid_q <= 1'b0;
            fetch_code_q  <= '0;
            entry_ack_q   <= 1'b0;
            entry_rej_q   <= 1'b0;
        end else begin
            fetch_valid_q <= 1'b0;
            entry_ack_q   <= 1'b0;
            entry_rej_q   <= 1'b0;
            if (run_go) begin
                bank_q  <= bank_sel;
                state_q <= SQ_RUN;
            end else if (pc_clear) begin
                bank_q  <= bank_sel;
                state_q <= SQ_IDLE;
            end else if (ent_take) begin
                if (do_entry) begin
                    entry_ack_q <= 1'b1;
                    bank_q      <= nxt_pos.bank;
                end else begin
                    entry_rej_q <= 1'b1;
                end
            end else if (fetch_live) begin
                if (!do_fetch) begin
                    state_q <= SQ_DONE;
                end else begin
                    fetch_valid_q <= 1'b1;
                    fetch_code_q  <= step_rd;
                    bank_q        <= nxt_pos.bank;
                    if (step_rd == OP_END)       state_q <= SQ_DONE;
                    else if (step_rd == OP_STOP) state_q <= SQ_HALT;
                end
            end else if ((state_q == SQ_HALT) && resume) begin
                state_q <= SQ_RUN;
            end
        end
    end

    always_comb begin
        running  = (state_q == SQ_RUN);
        halted   = (state_q == SQ_HALT);
        complete = (state_q == SQ_DONE);
    end

    // R6
    fetch_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid_q |-> $past(fetch_req) && $past(running));

    // R4
    reject_keeps_pc_chk: assert property (@(posedge clk) disable iff (rst)
        entry_rej_q |-> (pc_rd == $past(pc_rd)) && (bank_q == $past(bank_q)));

    // R4
    ack_reject_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({entry_ack_q, entry_rej_q, fetch_valid_q}));

    // R7
    no_fetch_while_halted_chk: assert property (@(posedge clk) disable iff (rst)
        halted && $past(halted) |-> !fetch_valid_q);

    // R8
    end_code_completes_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid_q && (fetch_code_q == OP_END) |-> complete && !running);
endmodule

// File: rtl/prog_step_seq.sv
module prog_step_seq
    import prog_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic              chain_en,
    input  logic              pc_clear,
    input  logic              ent_stb,
    input  logic [3:0]        ent_digit,
    input  logic              ent_point,
    input  logic              run_go,
    input  logic              fetch_req,
    input  logic              resume,
    output logic              fetch_valid,
    output logic [CODE_W-1:0] fetch_code,
    output logic              entry_ack,
    output logic              entry_reject,
    output logic              running,
    output logic              halted,
    output logic              complete,
    output logic              cur_bank,
    output logic [PC_W-1:0]   cur_pc
);
    logic              key_ok;
    logic [CODE_W-1:0] key_code;
    logic              st_we, st_bank, pc_we, pc_bank, bank_q;
    logic [PC_W-1:0]   st_idx, pc_data, pc_rd;
    logic [CODE_W-1:0] st_data, step_rd;

    key_code_enc u_enc (
        .digit   (ent_digit),
        .point   (ent_point),
        .code_ok (key_ok),
        .code    (key_code)
    );

    step_store u_store (
        .clk     (clk),
        .rst     (rst),
        .st_we   (st_we),
        .st_bank (st_bank),
        .st_idx  (st_idx),
        .st_data (st_data),
        .pc_we   (pc_we),
        .pc_bank (pc_bank),
        .pc_data (pc_data),
        .rd_bank (bank_q),
        .pc_rd   (pc_rd),
        .step_rd (step_rd)
    );

    seq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bank_sel      (bank_sel),
        .chain_en      (chain_en),
        .pc_clear      (pc_clear),
        .ent_stb       (ent_stb),
        .run_go        (run_go),
        .fetch_req     (fetch_req),
        .resume        (resume),
        .key_ok        (key_ok),
        .key_code      (key_code),
        .pc_rd         (pc_rd),
        .step_rd       (step_rd),
        .st_we         (st_we),
        .st_bank       (st_bank),
        .st_idx        (st_idx),
        .st_data       (st_data),
        .pc_we         (pc_we),
        .pc_bank       (pc_bank),
        .pc_data       (pc_data),
        .bank_q        (bank_q),
        .fetch_valid_q (fetch_valid),
        .fetch_code_q  (fetch_code),
        .entry_ack_q   (entry_ack),
        .entry_rej_q   (entry_reject),
        .running       (running),
        .halted        (halted),
        .complete      (complete)
    );

    always_comb begin
        cur_bank = bank_q;
        cur_pc   = pc_rd;
    end

    // R9
    chain_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_ack || fetch_valid) && cur_bank && !$past(cur_bank) |-> cur_pc == PC_W'(1));
endmodule

// File: tb/prog_step_seq_tb.sv
module prog_step_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bank_sel = 1'b0, chain_en = 1'b0, pc_clear = 1'b0, ent_stb = 1'b0;
    logic [3:0] ent_digit = '0;
    logic       ent_point = 1'b0, run_go = 1'b0, fetch_req = 1'b0, resume = 1'b0;
    logic       fetch_valid, entry_ack, entry_reject, running, halted, complete, cur_bank;
    logic [3:0] fetch_code, cur_pc;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    prog_step_seq u_dut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .chain_en(chain_en),
        .pc_clear(pc_clear), .ent_stb(ent_stb), .ent_digit(ent_digit),
        .ent_point(ent_point), .run_go(run_go), .fetch_req(fetch_req),
        .resume(resume), .fetch_valid(fetch_valid), .fetch_code(fetch_code),
        .entry_ack(entry_ack), .entry_reject(entry_reject), .running(running),
        .halted(halted), .complete(complete), .cur_bank(cur_bank), .cur_pc(cur_pc)
    );

    function automatic int exp_code(input int d, input bit p);
        return p ? 8 + d : d;
    endfunction

    function automatic bit exp_ok(input int d, input bit p);
        return p ? (d <= 7 && d != 5) : (d <= 9);
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic press(input int d, input bit p);
        @(negedge clk);
        ent_digit = 4'(d); ent_point = p; ent_stb = 1'b1;
        @(negedge clk);
        ent_stb = 1'b0;
    endtask

    task automatic clear_pc(input bit b);
        @(negedge clk);
        bank_sel = b; pc_clear = 1'b1;
        @(negedge clk);
        pc_clear = 1'b0;
    endtask

    task automatic start_run(input bit b);
        @(negedge clk);
        bank_sel = b; run_go = 1'b1;
        @(negedge clk);
        run_go = 1'b0;
    endtask

    task automatic fetch();
        @(negedge clk);
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic do_resume();
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int prog [16];
        int len;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(!running && !halted && !complete && !fetch_valid && !entry_ack && !entry_reject,
            "R1 flags", int'(running), 0);
        chk(cur_pc == 4'd1 && cur_bank == 1'b0, "R1 pc", int'(cur_pc), 1);

        // R2 plain digit entry
        clear_pc(1'b0);
        press(3, 1'b0);
        chk(entry_ack == 1'b1, "R2 ack", int'(entry_ack), 1);
        chk(cur_pc == 4'd2, "R2 pc step", int'(cur_pc), 2);

        // R4 rejected keys leave pc alone
        press(5, 1'b1);
        chk(entry_reject == 1'b1 && !entry_ack, "R4 code13 reject", int'(entry_reject), 1);
        chk(cur_pc == 4'd2, "R4 pc kept", int'(cur_pc), 2);
        press(9, 1'b1);
        chk(entry_reject == 1'b1, "R4 point digit9 reject", int'(entry_reject), 1);
        press(12, 1'b0);
        chk(entry_reject == 1'b1 && cur_pc == 4'd2, "R4 digit12 reject", int'(cur_pc), 2);
        // R3 point entries
        press(2, 1'b1);
        press(7, 1'b1);
        chk(cur_pc == 4'd4, "R3 pc after point entries", int'(cur_pc), 4);

        // R5 run start
        start_run(1'b0);
        chk(running && cur_pc == 4'd1 && cur_bank == 1'b0, "R5 run start", int'(cur_pc), 1);
        fetch();
        chk(fetch_valid && fetch_code == 4'd3, "R6 fetch digit", int'(fetch_code), 3);
        chk(cur_pc == 4'd2, "R6 pc advance", int'(cur_pc), 2);
        fetch();
        chk(fetch_valid && fetch_code == 4'd10, "R3 code10 stored", int'(fetch_code), 10);
        fetch();
        chk(fetch_valid && fetch_code == 4'd15, "R3 code15 stored", int'(fetch_code), 15);
        chk(complete && !running, "R8 end completes", int'(complete), 1);

        // R7 stop and resume
        clear_pc(1'b0);
        press(2, 1'b0); press(6, 1'b1); press(8, 1'b0); press(7, 1'b1);
        start_run(1'b0);
        fetch();
        chk(fetch_code == 4'd2, "R6 first step", int'(fetch_code), 2);
        fetch();
        chk(fetch_valid && fetch_code == 4'd14 && halted, "R7 stop halts", int'(halted), 1);
        fetch();
        chk(!fetch_valid && halted, "R7 no fetch when halted", int'(fetch_valid), 0);
        press(4, 1'b0);
        chk(!entry_ack && !entry_reject, "R7 entry ignored while halted", int'(entry_ack), 0);
        do_resume();
        chk(running && !halted, "R7 resumed", int'(running), 1);
        fetch();
        chk(fetch_valid && fetch_code == 4'd8, "R7 next after resume", int'(fetch_code), 8);
        fetch();
        chk(complete && fetch_code == 4'd15, "R8 end after resume", int'(fetch_code), 15);

        // R9 chained 30-step program
        @(negedge clk); chain_en = 1'b1;
        clear_pc(1'b0);
        for (int i = 0; i < 15; i++) press(1, 1'b0);
        chk(cur_bank == 1'b1 && cur_pc == 4'd1, "R9 entry flips bank", int'(cur_pc), 1);
        press(4, 1'b0); press(7, 1'b1);
        start_run(1'b0);
        for (int i = 0; i < 15; i++) begin
            fetch();
            chk(fetch_valid && fetch_code == 4'd1, "R9 bank1 step", int'(fetch_code), 1);
        end
        chk(cur_bank == 1'b1 && cur_pc == 4'd1, "R9 fetch flips bank", int'(cur_bank), 1);
        fetch();
        chk(fetch_code == 4'd4, "R9 bank2 first", int'(fetch_code), 4);
        fetch();
        chk(complete, "R9 chained end", int'(complete), 1);

        // R10 exhaustion without chaining
        @(negedge clk); chain_en = 1'b0;
        clear_pc(1'b0);
        for (int i = 0; i < 15; i++) press(2, 1'b0);
        chk(cur_pc == 4'd0 && cur_bank == 1'b0, "R10 exhausted pc", int'(cur_pc), 0);
        press(3, 1'b0);
        chk(entry_reject == 1'b1, "R10 full reject", int'(entry_reject), 1);
        start_run(1'b0);
        for (int i = 0; i < 15; i++) fetch();
        chk(fetch_code == 4'd2 && cur_pc == 4'd0, "R10 last step", int'(fetch_code), 2);
        fetch();
        chk(!fetch_valid && complete, "R10 fetch past end", int'(fetch_valid), 0);

        // R11 bank 2 writes leave bank 1 intact
        clear_pc(1'b1);
        press(9, 1'b0); press(7, 1'b1);
        start_run(1'b0);
        fetch();
        chk(fetch_code == 4'd2, "R11 bank1 intact", int'(fetch_code), 2);
        start_run(1'b1);
        fetch();
        chk(fetch_code == 4'd9 && cur_bank == 1'b1, "R11 bank2 data", int'(fetch_code), 9);

        // random programs, R2 R3 R4 R6 R8
        for (int it = 0; it < 20; it++) begin
            automatic bit b = 1'($urandom_range(0, 1));
            len = $urandom_range(1, 14);
            clear_pc(b);
            for (int k = 0; k < len; k++) begin
                automatic int d;
                automatic bit p;
                do begin
                    p = 1'($urandom_range(0, 1));
                    d = $urandom_range(0, 15);
                end while (exp_ok(d, p) && exp_code(d, p) >= 14);
                press(d, p);
                if (exp_ok(d, p)) begin
                    prog[k] = exp_code(d, p);
                    chk(entry_ack == 1'b1, "R2 random ack", int'(entry_ack), 1);
                end else begin
                    chk(entry_reject == 1'b1, "R4 random reject", int'(entry_reject), 1);
                    k--;
                end
            end
            press(7, 1'b1);
            start_run(b);
            for (int k = 0; k < len; k++) begin
                fetch();
                chk(fetch_valid && int'(fetch_code) == prog[k], "R6 random fetch",
                    int'(fetch_code), prog[k]);
            end
            fetch();
            chk(complete && fetch_code == 4'd15, "R8 random end", int'(fetch_code), 15);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule